// File: doc/BRIEF.md
# Keyed Flash-Programming Mode Gate

This block decides when a small SoC leaves normal operation and enters a dedicated flash-programming mode. Firmware must first write a mode code to a staging register and then write an unlock key to a second register. Only two codes open the mode. One of them starts a full erase of the flash array. The other opens the array for readback, and only while the security bit is clear. Every write to the key register empties the staging register, whether or not the key matched. A single stray write therefore cannot open the mode.

Once the mode is open, the block holds the processor core halted and keeps the compute engine disabled. It steers host SPI accesses to flash space and sends a reset pulse to the flash controller. The mode stays open until the next system reset. During that time the block inspects each SPI transaction at byte level, as delivered by the SPI front end. A write frame that breaks the framing rules is dropped and raises a sticky error flag. A legal write frame produces a single 16-bit word commit. A read frame produces one address strobe per data byte, and the address counts upward.

Top module: `flashmode_gate`

## Requirements
- R1: After reset, every output flag and strobe is low. The staging register reads 0x00 at address 0x2080, and the status register reads 0x00 at address 0x2082.
- R2: A write of 0xD1 to the staging register (0x2080), followed by a write of 0x96 to the key register (0x2081), opens the mode. `mode_active` goes high in the cycle after the key write is clocked.
- R3: A key-register write with any value other than 0x96 leaves the mode closed. Every key-register write returns the staging register to 0x00.
- R4: A staged value other than 0xD1 or 0x2E leaves the mode closed, even when the key is correct.
- R5: The readback code 0x2E opens the mode only while `sec_bit` is low. `sec_bit` is set by a one-cycle `sec_set` pulse.
- R6: When the mode opens, `core_halt`, `engine_off` and `flash_sel` rise together with `mode_active`. `flash_rst` is high for exactly one cycle, in that same first cycle.
- R7: Opening with 0xD1 raises `erase_req`, which stays high until `erase_done` is sampled high. In the cycle after that, `erase_req` and `sec_bit` are both low. Opening with 0x2E never raises `erase_req`.
- R8: `mode_active` and `core_halt` stay high through any further register writes and stay high until `rst_n` is asserted.
- R9: A write frame is legal when it has exactly six bytes in this order: command 0x00, address high byte, address low byte, data byte for the even address, data byte for the odd address, trailing byte. The address must also be even. A legal frame gives one `wr_stb` pulse in the cycle after `spi_end`, carrying that address and `{odd byte, even byte}` on `wr_data`.
- R10: A frame whose command has bit 7 clear is a write frame. A write frame with a command other than 0x00, a length other than six, or an odd address gives no `wr_stb` and sets `frame_err`. `frame_err` stays set until reset, and legal frames that follow still commit.
- R11: In a read frame with command 0x80, every byte after the two address bytes produces one `rd_stb` in the next cycle. `rd_addr` starts at the frame address and increases by one per byte. Any other command with bit 7 set produces no strobe and no error.
- R12: While the mode is closed, SPI traffic produces no `wr_stb`, no `rd_stb` and no `frame_err`.
- R13: The status register at 0x2082 reads with bit 0 as the mode-active flag, bit 1 as the security bit, bit 2 as the frame error flag and bit 3 as erase pending. All other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the pin, watchdog and power-on resets are combined into it |
| reg_wr_en | input | 1 | Register bus write strobe |
| reg_addr | input | 16 | Register bus address (also used for reads) |
| reg_wdata | input | 8 | Register bus write data |
| reg_rdata | output | 8 | Register read data for `reg_addr`, combinational |
| sec_set | input | 1 | Pulse that sets the security bit |
| erase_done | input | 1 | Flash array reports that the mass erase has finished |
| spi_byte_vld | input | 1 | One received SPI byte is on `spi_byte` |
| spi_byte | input | 8 | Received SPI byte |
| spi_end | input | 1 | Pulse at the end of an SPI transaction |
| mode_active | output | 1 | Flash-programming mode is open |
| core_halt | output | 1 | Halt request to the processor core |
| engine_off | output | 1 | Disable for the compute engine |
| flash_sel | output | 1 | Steers SPI accesses to flash space instead of XRAM |
| flash_rst | output | 1 | Reset pulse to the flash controller on entry |
| erase_req | output | 1 | Mass erase request, held until done |
| sec_bit | output | 1 | Security bit |
| frame_err | output | 1 | Sticky SPI write framing error |
| wr_stb | output | 1 | Legal write word commit |
| wr_addr | output | 16 | Even address of the committed word |
| wr_data | output | 16 | Committed word: high byte for the odd address, low byte for the even address |
| rd_stb | output | 1 | Read byte strobe |
| rd_addr | output | 16 | Address of the read byte |

## Verification
The assertions take two things for granted about the inputs. First, `spi_end` never arrives in the same cycle as `spi_byte_vld`. Second, `erase_done` only matters while an erase is pending. The bench drives every SPI byte and every end pulse in a separate cycle, and it pulses `erase_done` only after it has observed `erase_req` high. Register writes are always one cycle long with stable address and data, so each key check sees exactly one write.

// File: rtl/fmg_pkg.sv
package fmg_pkg;
   localparam int unsigned REG_AW = 16;
   localparam int unsigned REG_DW = 8;

   localparam logic [REG_AW-1:0] DEF_STAGE_ADDR  = 16'h2080;
   localparam logic [REG_AW-1:0] DEF_KEY_ADDR    = 16'h2081;
   localparam logic [REG_AW-1:0] DEF_STATUS_ADDR = 16'h2082;

   localparam logic [REG_DW-1:0] DEF_KEY_VAL    = 8'h96;
   localparam logic [REG_DW-1:0] DEF_CODE_ERASE = 8'hD1;
   localparam logic [REG_DW-1:0] DEF_CODE_READ  = 8'h2E;

   localparam logic [7:0] DEF_CMD_WR = 8'h00;
   localparam logic [7:0] DEF_CMD_RD = 8'h80;

   // status register bit positions
   typedef enum int unsigned {
      ST_ACTIVE = 0,
      ST_SEC    = 1,
      ST_FERR   = 2,
      ST_ERASE  = 3
   } status_bit_e;
endpackage

// File: rtl/fmg_keyseq.sv
module fmg_keyseq
   import fmg_pkg::*;
#(
   parameter int unsigned      AW         = REG_AW,
   parameter int unsigned      DW         = REG_DW,
   parameter logic [AW-1:0]    STAGE_ADDR = DEF_STAGE_ADDR,
   parameter logic [AW-1:0]    KEY_ADDR   = DEF_KEY_ADDR,
   parameter logic [DW-1:0]    KEY_VAL    = DEF_KEY_VAL,
   parameter logic [DW-1:0]    CODE_ERASE = DEF_CODE_ERASE,
   parameter logic [DW-1:0]    CODE_READ  = DEF_CODE_READ
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en_i,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] wdata_i,
   input  logic          sec_i,
   output logic [DW-1:0] staged_o,
   output logic          enter_o,
   output logic          enter_erase_o
);
   logic [DW-1:0] staged_q;
   logic          hit_stage, hit_key, key_ok, code_erase, code_read;

   assign hit_stage  = wr_en_i && (addr_i == STAGE_ADDR);
   assign hit_key    = wr_en_i && (addr_i == KEY_ADDR);
   assign key_ok     = (wdata_i == KEY_VAL);
   assign code_erase = (staged_q == CODE_ERASE);
   assign code_read  = (staged_q == CODE_READ) && !sec_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         staged_q <= '0;
      end else if (hit_key) begin
         staged_q <= '0;          // every key write empties the stage
      end else if (hit_stage) begin
         staged_q <= wdata_i;
      end
   end

   assign enter_o       = hit_key && key_ok && (code_erase || code_read);
   assign enter_erase_o = hit_key && key_ok && code_erase;
   assign staged_o      = staged_q;
endmodule

// File: rtl/fmg_erase_ctl.sv
module fmg_erase_ctl #(
   parameter int unsigned RST_CYC = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enter_i,
   input  logic enter_erase_i,
   input  logic erase_done_i,
   input  logic sec_set_i,
   output logic erase_req_o,
   output logic sec_o,
   output logic flash_rst_o
);
   logic erase_q, sec_q, finish;

   assign finish = erase_q && erase_done_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         erase_q <= 1'b0;
      end else if (enter_erase_i) begin
         erase_q <= 1'b1;
      end else if (finish) begin
         erase_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec_q <= 1'b0;
      end else if (finish) begin
         sec_q <= 1'b0;           // completed erase clears security
      end else if (sec_set_i) begin
         sec_q <= 1'b1;
      end
   end

   generate
      if (RST_CYC == 1) begin : g_rst_single
         logic pulse_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pulse_q <= 1'b0;
            else        pulse_q <= enter_i;
         end
         assign flash_rst_o = pulse_q;
      end else begin : g_rst_count
         localparam int unsigned RCW = $clog2(RST_CYC + 1);
         localparam logic [RCW-1:0] RLOAD = RCW'(RST_CYC);
         logic [RCW-1:0] rcnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              rcnt_q <= '0;
            else if (enter_i)        rcnt_q <= RLOAD;
            else if (rcnt_q != '0)   rcnt_q <= rcnt_q - 1'b1;
         end
         assign flash_rst_o = (rcnt_q != '0);
      end
   endgenerate

   assign erase_req_o = erase_q;
   assign sec_o       = sec_q;
endmodule

// File: rtl/fmg_spi_frame.sv
module fmg_spi_frame
   import fmg_pkg::*;
#(
   parameter int unsigned ADDR_BYTES   = 2,
   parameter int unsigned WR_FRAME_LEN = 6,
   parameter logic [7:0]  CMD_WR       = DEF_CMD_WR,
   parameter logic [7:0]  CMD_RD       = DEF_CMD_RD,
   localparam int unsigned SAW         = 8 * ADDR_BYTES
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           active_i,
   input  logic           byte_vld_i,
   input  logic [7:0]     byte_i,
   input  logic           end_i,
   output logic           err_o,
   output logic           wr_stb_o,
   output logic [SAW-1:0] wr_addr_o,
   output logic [15:0]    wr_data_o,
   output logic           rd_stb_o,
   output logic [SAW-1:0] rd_addr_o
);
   localparam int unsigned HDR = 1 + ADDR_BYTES;
   localparam int unsigned SAT = WR_FRAME_LEN + 1;
   localparam int unsigned CW  = $clog2(SAT + 1);
   localparam logic [CW-1:0] HDR_C  = CW'(HDR);
   localparam logic [CW-1:0] HDR1_C = CW'(HDR + 1);
   localparam logic [CW-1:0] LEN_C  = CW'(WR_FRAME_LEN);
   localparam logic [CW-1:0] SAT_C  = CW'(SAT);

   logic [CW-1:0]  cnt_q;
   logic [7:0]     cmd_q;
   logic [SAW-1:0] addr_q;
   logic [7:0]     d_even_q, d_odd_q;
   logic           err_q;
   logic           is_write, wr_legal;

   assign is_write = !cmd_q[7];
   assign wr_legal = (cmd_q == CMD_WR) && (cnt_q == LEN_C) && !addr_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         cmd_q     <= '0;
         addr_q    <= '0;
         d_even_q  <= '0;
         d_odd_q   <= '0;
         err_q     <= 1'b0;
         wr_stb_o  <= 1'b0;
         wr_addr_o <= '0;
         wr_data_o <= '0;
         rd_stb_o  <= 1'b0;
         rd_addr_o <= '0;
      end else begin
         wr_stb_o <= 1'b0;
         rd_stb_o <= 1'b0;
         if (!active_i) begin
            cnt_q <= '0;
         end else if (byte_vld_i) begin
            if (cnt_q != SAT_C) cnt_q <= cnt_q + 1'b1;
            if (cnt_q == '0) begin
               cmd_q <= byte_i;
            end else if (cnt_q < HDR_C) begin
               addr_q <= (addr_q << 8) | SAW'(byte_i);
            end else begin
               if (cnt_q == HDR_C)  d_even_q <= byte_i;
               if (cnt_q == HDR1_C) d_odd_q  <= byte_i;
               if (cmd_q == CMD_RD) begin
                  rd_stb_o  <= 1'b1;
                  rd_addr_o <= addr_q;
                  addr_q    <= addr_q + 1'b1;   // reads auto-increment
               end
            end
         end else if (end_i) begin
            cnt_q <= '0;
            if (cnt_q != '0 && is_write) begin
               if (wr_legal) begin
                  wr_stb_o  <= 1'b1;
                  wr_addr_o <= addr_q;
                  wr_data_o <= {d_odd_q, d_even_q};
               end else begin
                  err_q <= 1'b1;
               end
            end
         end
      end
   end

   assign err_o = err_q;
endmodule

// File: rtl/flashmode_gate.sv
module flashmode_gate
   import fmg_pkg::*;
#(
   parameter logic [15:0] STAGE_ADDR   = DEF_STAGE_ADDR,
   parameter logic [15:0] KEY_ADDR     = DEF_KEY_ADDR,
   parameter logic [15:0] STATUS_ADDR  = DEF_STATUS_ADDR,
   parameter logic [7:0]  KEY_VAL      = DEF_KEY_VAL,
   parameter logic [7:0]  CODE_ERASE   = DEF_CODE_ERASE,
   parameter logic [7:0]  CODE_READ    = DEF_CODE_READ,
   parameter int unsigned RST_CYC      = 1,
   parameter int unsigned WR_FRAME_LEN = 6
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr_en,
   input  logic [15:0] reg_addr,
   input  logic [7:0]  reg_wdata,
   output logic [7:0]  reg_rdata,
   input  logic        sec_set,
   input  logic        erase_done,
   input  logic        spi_byte_vld,
   input  logic [7:0]  spi_byte,
   input  logic        spi_end,
   output logic        mode_active,
   output logic        core_halt,
   output logic        engine_off,
   output logic        flash_sel,
   output logic        flash_rst,
   output logic        erase_req,
   output logic        sec_bit,
   output logic        frame_err,
   output logic        wr_stb,
   output logic [15:0] wr_addr,
   output logic [15:0] wr_data,
   output logic        rd_stb,
   output logic [15:0] rd_addr
);
   localparam int unsigned ADDR_BYTES = 2;

   generate
      if (KEY_ADDR == STAGE_ADDR || STATUS_ADDR == KEY_ADDR || STATUS_ADDR == STAGE_ADDR) begin : g_bad_map
         $error("flashmode_gate: register addresses must differ");
      end
      if (CODE_ERASE == CODE_READ) begin : g_bad_codes
         $error("flashmode_gate: mode codes must differ");
      end
      if (WR_FRAME_LEN < 1 + ADDR_BYTES + 2) begin : g_bad_len
         $error("flashmode_gate: write frame too short for header and one word");
      end
      if (RST_CYC < 1) begin : g_bad_rst
         $error("flashmode_gate: reset pulse needs at least one cycle");
      end
   endgenerate

   logic [7:0] staged;
   logic       enter_raw, enter_erase_raw, enter_ok, enter_erase_ok;
   logic       active_q;

   fmg_keyseq #(
      .AW(16), .DW(8),
      .STAGE_ADDR(STAGE_ADDR), .KEY_ADDR(KEY_ADDR), .KEY_VAL(KEY_VAL),
      .CODE_ERASE(CODE_ERASE), .CODE_READ(CODE_READ)
   ) u_keyseq (
      .clk(clk), .rst_n(rst_n),
      .wr_en_i(reg_wr_en), .addr_i(reg_addr), .wdata_i(reg_wdata),
      .sec_i(sec_bit),
      .staged_o(staged), .enter_o(enter_raw), .enter_erase_o(enter_erase_raw)
   );

   assign enter_ok       = enter_raw && !active_q;
   assign enter_erase_ok = enter_erase_raw && !active_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        active_q <= 1'b0;
      else if (enter_ok) active_q <= 1'b1;
   end

   fmg_erase_ctl #(.RST_CYC(RST_CYC)) u_erase (
      .clk(clk), .rst_n(rst_n),
      .enter_i(enter_ok), .enter_erase_i(enter_erase_ok),
      .erase_done_i(erase_done), .sec_set_i(sec_set),
      .erase_req_o(erase_req), .sec_o(sec_bit), .flash_rst_o(flash_rst)
   );

   fmg_spi_frame #(
      .ADDR_BYTES(ADDR_BYTES), .WR_FRAME_LEN(WR_FRAME_LEN)
   ) u_frame (
      .clk(clk), .rst_n(rst_n), .active_i(active_q),
      .byte_vld_i(spi_byte_vld), .byte_i(spi_byte), .end_i(spi_end),
      .err_o(frame_err),
      .wr_stb_o(wr_stb), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
      .rd_stb_o(rd_stb), .rd_addr_o(rd_addr)
   );

   assign mode_active = active_q;
   assign core_halt   = active_q;
   assign engine_off  = active_q;
   assign flash_sel   = active_q;

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == STAGE_ADDR) begin
         reg_rdata = staged;
      end else if (reg_addr == STATUS_ADDR) begin
         reg_rdata[ST_ACTIVE] = active_q;
         reg_rdata[ST_SEC]    = sec_bit;
         reg_rdata[ST_FERR]   = frame_err;
         reg_rdata[ST_ERASE]  = erase_req;
      end
   end
endmodule

// File: rtl/fmg_checker.sv
module fmg_checker #(
   parameter logic [15:0] KEY_ADDR = 16'h2081,
   parameter logic [7:0]  KEY_VAL  = 8'h96
) (
   input logic        clk,
   input logic        rst_n,
   input logic        reg_wr_en,
   input logic [15:0] reg_addr,
   input logic [7:0]  reg_wdata,
   input logic        erase_done,
   input logic        mode_active,
   input logic        core_halt,
   input logic        flash_rst,
   input logic        erase_req,
   input logic        sec_bit,
   input logic        frame_err,
   input logic        wr_stb,
   input logic [15:0] wr_addr,
   input logic        rd_stb
);
   p_entry_needs_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mode_active) |-> $past(reg_wr_en && reg_addr == KEY_ADDR && reg_wdata == KEY_VAL));

   p_rst_pulse_on_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mode_active) |-> flash_rst);

   p_mode_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mode_active |=> (mode_active && core_halt));

   p_erase_done_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_req && erase_done) |=> (!erase_req && !sec_bit));

   p_erase_needs_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
      erase_req |-> mode_active);

   p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |=> frame_err);

   p_even_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> !wr_addr[0]);

   p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_active |-> (!wr_stb && !rd_stb && !frame_err));
endmodule

bind flashmode_gate fmg_checker #(.KEY_ADDR(KEY_ADDR), .KEY_VAL(KEY_VAL)) u_fmg_chk (
   .clk(clk), .rst_n(rst_n),
   .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
   .erase_done(erase_done),
   .mode_active(mode_active), .core_halt(core_halt), .flash_rst(flash_rst),
   .erase_req(erase_req), .sec_bit(sec_bit), .frame_err(frame_err),
   .wr_stb(wr_stb), .wr_addr(wr_addr), .rd_stb(rd_stb)
);

// File: tb/flashmode_gate_tb_top.sv
`timescale 1ns/1ps
module flashmode_gate_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [15:0] reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        sec_set = 1'b0, erase_done = 1'b0;
   logic        spi_byte_vld = 1'b0, spi_end = 1'b0;
   logic [7:0]  spi_byte = '0;
   logic        mode_active, core_halt, engine_off, flash_sel, flash_rst;
   logic        erase_req, sec_bit, frame_err, wr_stb, rd_stb;
   logic [15:0] wr_addr, wr_data, rd_addr;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;
   logic [31:0] wr_q[$];
   logic [15:0] rd_q[$];

   always #10 clk = ~clk;   // 50 MHz

   flashmode_gate dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sec_set(sec_set),
      .erase_done(erase_done), .spi_byte_vld(spi_byte_vld), .spi_byte(spi_byte),
      .spi_end(spi_end), .mode_active(mode_active), .core_halt(core_halt),
      .engine_off(engine_off), .flash_sel(flash_sel), .flash_rst(flash_rst),
      .erase_req(erase_req), .sec_bit(sec_bit), .frame_err(frame_err),
      .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_stb(rd_stb), .rd_addr(rd_addr)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && wr_stb) begin
         if (wr_q.size() == 0) chk(0, "R9/R10 unexpected wr_stb", {wr_addr, wr_data}, 32'h0);
         else begin
            logic [31:0] e;
            e = wr_q.pop_front();
            chk({wr_addr, wr_data} == e, "R9 write commit", {wr_addr, wr_data}, e);
         end
      end
      if (rst_n && rd_stb) begin
         if (rd_q.size() == 0) chk(0, "R11/R12 unexpected rd_stb", {16'h0, rd_addr}, 32'h0);
         else begin
            logic [15:0] e;
            e = rd_q.pop_front();
            chk(rd_addr == e, "R11 read address", {16'h0, rd_addr}, {16'h0, e});
         end
      end
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
      idle(1);
   endtask

   task automatic reg_wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic reg_rd(input logic [15:0] a, output logic [7:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic spi_xfer(input logic [7:0] b [8], input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); spi_byte_vld = 1'b1; spi_byte = b[i];
      end
      @(negedge clk); spi_byte_vld = 1'b0; spi_end = 1'b1;
      @(negedge clk); spi_end = 1'b0;
      idle(2);
   endtask

   task automatic pulse_sec();
      @(negedge clk); sec_set = 1'b1;
      @(negedge clk); sec_set = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         chk(0, "watchdog expired", 32'h0, 32'h1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] rv;
      logic [7:0] fr [8];
      idle(2);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      chk(!mode_active && !core_halt && !engine_off && !flash_sel, "R1 mode outputs", {28'h0, mode_active, core_halt, engine_off, flash_sel}, 32'h0);
      chk(!flash_rst && !erase_req && !sec_bit && !frame_err, "R1 side outputs", {28'h0, flash_rst, erase_req, sec_bit, frame_err}, 32'h0);
      reg_rd(16'h2080, rv); chk(rv == 8'h00, "R1 stage reg", {24'h0, rv}, 32'h0);
      reg_rd(16'h2082, rv); chk(rv == 8'h00, "R1 status reg", {24'h0, rv}, 32'h0);

      // R12 traffic while closed
      fr = '{8'h00, 8'h00, 8'h40, 8'h11, 8'h22, 8'h00, 8'h00, 8'h00};
      spi_xfer(fr, 6);
      fr = '{8'h80, 8'h00, 8'h40, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
      spi_xfer(fr, 4);
      chk(!frame_err, "R12 no error while closed", {31'h0, frame_err}, 32'h0);

      // R3 wrong key, stage cleared
      reg_wr(16'h2080, 8'hD1);
      reg_rd(16'h2080, rv); chk(rv == 8'hD1, "R3 stage holds value", {24'h0, rv}, 32'hD1);
      reg_wr(16'h2081, 8'h55);
      chk(!mode_active, "R3 wrong key stays closed", {31'h0, mode_active}, 32'h0);
      reg_rd(16'h2080, rv); chk(rv == 8'h00, "R3 stage cleared by key write", {24'h0, rv}, 32'h0);
      reg_wr(16'h2081, 8'h96);
      chk(!mode_active, "R3 correct key after clear stays closed", {31'h0, mode_active}, 32'h0);

      // R4 unknown code
      reg_wr(16'h2080, 8'h12);
      reg_wr(16'h2081, 8'h96);
      chk(!mode_active, "R4 unknown code", {31'h0, mode_active}, 32'h0);

      // R5 readback blocked by security
      pulse_sec();
      chk(sec_bit, "R5 sec set", {31'h0, sec_bit}, 32'h1);
      reg_wr(16'h2080, 8'h2E);
      reg_wr(16'h2081, 8'h96);
      chk(!mode_active, "R5 readback blocked when secure", {31'h0, mode_active}, 32'h0);
      reg_rd(16'h2082, rv); chk(rv == 8'h02, "R13 status secure only", {24'h0, rv}, 32'h02);

      // R2/R6/R7 erase entry
      reg_wr(16'h2080, 8'hD1);
      reg_wr(16'h2081, 8'h96);
      chk(mode_active, "R2 erase code opens mode", {31'h0, mode_active}, 32'h1);
      chk(core_halt && engine_off && flash_sel, "R6 entry outputs", {29'h0, core_halt, engine_off, flash_sel}, 32'h7);
      chk(flash_rst, "R6 flash reset pulse high", {31'h0, flash_rst}, 32'h1);
      chk(erase_req && sec_bit, "R7 erase requested, sec still set", {30'h0, erase_req, sec_bit}, 32'h3);
      idle(1);
      chk(!flash_rst, "R6 flash reset pulse one cycle", {31'h0, flash_rst}, 32'h0);
      idle(3);
      chk(erase_req, "R7 erase held", {31'h0, erase_req}, 32'h1);
      reg_rd(16'h2082, rv); chk(rv == 8'h0B, "R13 status during erase", {24'h0, rv}, 32'h0B);
      @(negedge clk); erase_done = 1'b1;
      @(negedge clk); erase_done = 1'b0;
      chk(!erase_req && !sec_bit, "R7 done clears erase and sec", {30'h0, erase_req, sec_bit}, 32'h0);

      // R9 legal write
      wr_q.push_back({16'h1234, 16'hBBAA});
      fr = '{8'h00, 8'h12, 8'h34, 8'hAA, 8'hBB, 8'h5A, 8'h00, 8'h00};
      spi_xfer(fr, 6);
      chk(wr_q.size() == 0 && !frame_err, "R9 legal write committed", {31'h0, frame_err}, 32'h0);

      // R10 odd address
      fr = '{8'h00, 8'h12, 8'h35, 8'hAA, 8'hBB, 8'h00, 8'h00, 8'h00};
      spi_xfer(fr, 6);
      chk(frame_err, "R10 odd address flagged", {31'h0, frame_err}, 32'h1);
      reg_rd(16'h2082, rv); chk(rv == 8'h05, "R13 status with error", {24'h0, rv}, 32'h05);

      // R11 read burst, then foreign read command
      rd_q.push_back(16'h0010); rd_q.push_back(16'h0011); rd_q.push_back(16'h0012);
      fr = '{8'h80, 8'h00, 8'h10, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
      spi_xfer(fr, 6);
      chk(rd_q.size() == 0, "R11 three read strobes", rd_q.size(), 32'h0);
      fr = '{8'h81, 8'h00, 8'h10, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
      spi_xfer(fr, 5);

      // R10 sticky, later legal write still commits
      wr_q.push_back({16'h0100, 16'h2211});
      fr = '{8'h00, 8'h01, 8'h00, 8'h11, 8'h22, 8'h00, 8'h00, 8'h00};
      spi_xfer(fr, 6);
      chk(frame_err && wr_q.size() == 0, "R10 error sticky, legal frame commits", {31'h0, frame_err}, 32'h1);

      // R8 stays open
      reg_wr(16'h2081, 8'h00);
      reg_wr(16'h2080, 8'h00);
      idle(50);
      chk(mode_active && core_halt, "R8 mode sticky", {30'h0, mode_active, core_halt}, 32'h3);

      // reset clears everything
      do_reset();
      chk(!mode_active && !frame_err && !core_halt, "R8/R10 reset closes and clears", {29'h0, mode_active, frame_err, core_halt}, 32'h0);

      // R5 readback entry with sec clear, R7 no erase
      reg_wr(16'h2080, 8'h2E);
      reg_wr(16'h2081, 8'h96);
      chk(mode_active && flash_rst, "R5 readback opens when not secure", {30'h0, mode_active, flash_rst}, 32'h3);
      chk(!erase_req, "R7 readback has no erase", {31'h0, erase_req}, 32'h0);

      // R10 wrong length
      fr = '{8'h00, 8'h00, 8'h20, 8'h01, 8'h02, 8'h00, 8'h00, 8'h00};
      spi_xfer(fr, 5);
      chk(frame_err, "R10 short write flagged", {31'h0, frame_err}, 32'h1);

      // R10 bad write command
      do_reset();
      reg_wr(16'h2080, 8'h2E);
      reg_wr(16'h2081, 8'h96);
      fr = '{8'h01, 8'h00, 8'h20, 8'h01, 8'h02, 8'h00, 8'h00, 8'h00};
      spi_xfer(fr, 6);
      chk(frame_err, "R10 bad write command flagged", {31'h0, frame_err}, 32'h1);
      fr = '{8'h00, 8'h00, 8'h20, 8'h01, 8'h02, 8'h00, 8'h00, 8'h00};
      spi_xfer(fr, 7);
      chk(wr_q.size() == 0 && rd_q.size() == 0, "R9 scoreboard drained", wr_q.size() + rd_q.size(), 32'h0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule